// File: doc/BRIEF.md
# Dual-Channel Up/Down Pulse Counter

This block counts pulses on two input channels into a single signed counter. Each channel has an edge input, whose rising and falling edges are the events counted, and a control input, whose level can keep, reverse or suppress the count direction chosen by the edge. Both inputs of each channel pass through a two-flop synchronizer, an optional glitch filter and an optional inverter before they are used. Both channels feed the counter at the same time, so quadrature and direction-plus-step encoders can be decoded without extra logic.

The counter is bounded by an active high limit and an active low limit. When the count reaches either limit, it wraps to zero and raises a limit event. Two programmable threshold comparators and a zero detector raise further events. Enabled events are latched into a sticky status mask and set an interrupt flag. A single write-one pulse clears both. Start, stop and clear arrive as one-cycle pulses from a register interface. Limit values written on the inputs are taken into use only when a clear is applied.

Top module: `pulse_counter_unit`

## Requirements
- R1: After reset the count is 0, the event status mask is 0, the interrupt flag is 0 and the counter is stopped. The active limits are +LIM_MAX and -LIM_MAX.
- R2: Each channel has a 2-bit mode for rising edges and one for falling edges of its conditioned edge input. The codes are 0 = no change, 1 = count up, 2 = count down and 3 = no change. A channel's pair of fields sits at bits [2c+1:2c] of the mode buses.
- R3: Each channel has a 2-bit mode for control high and one for control low. The codes are 0 = use the edge decision, 1 = reverse up and down, and 2 or 3 = no change.
- R4: A set invert bit complements the corresponding edge or control input before edge detection and level decoding.
- R5: With the glitch filter off, an input change that is stable before a clock edge alters the count at the fourth rising edge after it. When both channels step in the same cycle, their net step (−2..+2) is applied at once.
- R6: The count changes only while the counter is running. A start pulse takes effect for counting from the next cycle. Stop has priority over a start in the same cycle. Edges that occur while stopped are lost.
- R7: A clear pulse forces the count to 0 on the next edge and takes priority over counting in that cycle. It leaves the running state and the mode settings unchanged.
- R8: If a step takes the count to at or above the active high limit, the count becomes 0 and event bit 3 fires. If it takes the count to at or below the active low limit, the count becomes 0 and event bit 2 fires. A limit hit suppresses the threshold and zero events for that step.
- R9: The limit inputs are copied into the active limits only on a clear. The high value is copied only if it lies in 1..LIM_MAX, and the low value only if it lies in −LIM_MAX..−1; otherwise the previous active value is kept.
- R10: A step that lands exactly on threshold A (thresh_i low half) fires event bit 0, and one that lands on threshold B (thresh_i high half) fires event bit 1.
- R11: A step that lands on 0 without a limit hit fires event bit 4. A clear or a wrap to 0 does not fire it.
- R12: An event is latched into the status mask and sets the interrupt flag only if its bit in evt_en_i is 1. Status and interrupt hold until irq_clr_i is pulsed, and an event in the same cycle as irq_clr_i wins.
- R13: With the glitch filter enabled and a length of L, an input level must persist for L+1 consecutive synchronized cycles before it is accepted, so shorter pulses are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_in_i | input | 2 | Raw edge input per channel |
| ctrl_in_i | input | 2 | Raw control input per channel |
| edge_inv_i | input | 2 | Invert edge input per channel |
| ctrl_inv_i | input | 2 | Invert control input per channel |
| pos_mode_i | input | 4 | Rising-edge mode, 2 bits per channel |
| neg_mode_i | input | 4 | Falling-edge mode, 2 bits per channel |
| hi_mode_i | input | 4 | Control-high mode, 2 bits per channel |
| lo_mode_i | input | 4 | Control-low mode, 2 bits per channel |
| glitch_en_i | input | 1 | Glitch filter enable |
| glitch_len_i | input | FW | Glitch filter length in cycles |
| lim_hi_i | input | CW | High limit, loaded on clear |
| lim_lo_i | input | CW | Low limit, loaded on clear |
| thresh_i | input | 2*CW | Threshold B (high half) and threshold A (low half) |
| evt_en_i | input | 5 | Event enables: 0 thr A, 1 thr B, 2 low, 3 high, 4 zero |
| start_i | input | 1 | Start counting pulse |
| stop_i | input | 1 | Stop counting pulse |
| clear_i | input | 1 | Clear count and load limits pulse |
| irq_clr_i | input | 1 | Clear status mask and interrupt pulse |
| count_o | output | CW | Signed count |
| evt_status_o | output | 5 | Sticky event status mask |
| irq_o | output | 1 | Interrupt flag |

## Verification
A wrong step decode, a missed edge or a wrong limit comparison puts count_o off the reference value on the very clock where the step lands. This happens four cycles after the input change, or L cycles later with the filter on. A wrong active limit or a failed suppression of threshold and zero events shows up as a spurious or missing bit in evt_status_o in that same cycle. The status bits are sticky, so such a fault stays visible until the next interrupt clear. Because the reference model is compared on every clock, a fault is reported at the first cycle in which it differs, not at the end of a phase.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  typedef enum logic [1:0] {
    EA_HOLD = 2'd0,
    EA_UP   = 2'd1,
    EA_DOWN = 2'd2,
    EA_NONE = 2'd3
  } edge_mode_e;

  typedef enum logic [1:0] {
    LM_KEEP    = 2'd0,
    LM_REVERSE = 2'd1,
    LM_HOLD    = 2'd2,
    LM_NONE    = 2'd3
  } lvl_mode_e;

  localparam int NTHR    = 2;
  localparam int EV_LOW  = 2;
  localparam int EV_HIGH = 3;
  localparam int EV_ZERO = 4;
  localparam int EV_NUM  = 5;
endpackage

// File: rtl/pcnt_sig_cond.sv
module pcnt_sig_cond #(
  parameter int FW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raw_i,
  input  logic          filt_en_i,
  input  logic [FW-1:0] filt_len_i,
  input  logic          inv_i,
  output logic          cond_o
);
  logic          sync1_q, sync2_q;
  logic          filt_q, filt_d;
  logic [FW-1:0] run_q, run_d;

  always_comb begin
    filt_d = filt_q;
    run_d  = '0;
    if (sync2_q != filt_q) begin
      if (!filt_en_i || run_q >= filt_len_i) begin
        filt_d = sync2_q;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      filt_q  <= 1'b0;
      run_q   <= '0;
    end else begin
      sync1_q <= raw_i;
      sync2_q <= sync1_q;
      filt_q  <= filt_d;
      run_q   <= run_d;
    end
  end

  assign cond_o = filt_q ^ inv_i;
endmodule

// File: rtl/pcnt_chan.sv
module pcnt_chan
  import pcnt_pkg::*;
#(
  parameter int FW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_raw_i,
  input  logic          ctrl_raw_i,
  input  logic          edge_inv_i,
  input  logic          ctrl_inv_i,
  input  logic          filt_en_i,
  input  logic [FW-1:0] filt_len_i,
  input  logic [1:0]    pos_mode_i,
  input  logic [1:0]    neg_mode_i,
  input  logic [1:0]    hi_mode_i,
  input  logic [1:0]    lo_mode_i,
  output logic          up_o,
  output logic          down_o
);
  logic       edge_c, ctrl_c, edge_prev_q;
  logic       rise, fall, up_e, down_e;
  edge_mode_e emode;
  lvl_mode_e  lmode;

  pcnt_sig_cond #(.FW(FW)) edge_cond_i (
    .clk(clk), .rst_n(rst_n), .raw_i(edge_raw_i), .filt_en_i(filt_en_i),
    .filt_len_i(filt_len_i), .inv_i(edge_inv_i), .cond_o(edge_c)
  );

  pcnt_sig_cond #(.FW(FW)) ctrl_cond_i (
    .clk(clk), .rst_n(rst_n), .raw_i(ctrl_raw_i), .filt_en_i(filt_en_i),
    .filt_len_i(filt_len_i), .inv_i(ctrl_inv_i), .cond_o(ctrl_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_prev_q <= 1'b0;
    else        edge_prev_q <= edge_c;
  end

  always_comb begin
    rise  = edge_c & ~edge_prev_q;
    fall  = ~edge_c & edge_prev_q;
    emode = rise ? edge_mode_e'(pos_mode_i)
          : fall ? edge_mode_e'(neg_mode_i) : EA_HOLD;
    lmode = ctrl_c ? lvl_mode_e'(hi_mode_i) : lvl_mode_e'(lo_mode_i);
    up_e   = (emode == EA_UP);
    down_e = (emode == EA_DOWN);
    case (lmode)
      LM_KEEP:    begin up_o = up_e;   down_o = down_e; end
      LM_REVERSE: begin up_o = down_e; down_o = up_e;   end
      default:    begin up_o = 1'b0;   down_o = 1'b0;   end
    endcase
  end
endmodule

// File: rtl/pcnt_core.sv
module pcnt_core
  import pcnt_pkg::*;
#(
  parameter int CW      = 16,
  parameter int LIM_MAX = 32767,
  parameter int NCH     = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         up_i,
  input  logic [NCH-1:0]         down_i,
  input  logic                   start_i,
  input  logic                   stop_i,
  input  logic                   clear_i,
  input  logic                   irq_clr_i,
  input  logic signed [CW-1:0]   lim_hi_i,
  input  logic signed [CW-1:0]   lim_lo_i,
  input  logic [NTHR*CW-1:0]     thresh_i,
  input  logic [EV_NUM-1:0]      evt_en_i,
  output logic signed [CW-1:0]   count_o,
  output logic [EV_NUM-1:0]      evt_status_o,
  output logic                   irq_o,
  output logic signed [CW-1:0]   act_hi_o,
  output logic signed [CW-1:0]   act_lo_o,
  output logic                   run_o
);
  localparam int SW = CW + 2;
  localparam logic signed [CW-1:0] ZERO = '0;
  localparam logic signed [CW-1:0] LMAX = LIM_MAX[CW-1:0];
  localparam logic signed [CW-1:0] LMIN = -LMAX;
  localparam logic signed [SW-1:0] ONE  = 1;

  logic signed [CW-1:0] count_q, count_d, hi_q, hi_d, lo_q, lo_d;
  logic                 run_q, run_d, irq_q, irq_d;
  logic [EV_NUM-1:0]    stat_q, stat_d, ev, fire;
  logic signed [SW-1:0] step, nxt, hi_x, lo_x;
  logic [NTHR-1:0]      thr_hit;

  assign nxt  = {{2{count_q[CW-1]}}, count_q} + step;
  assign hi_x = {{2{hi_q[CW-1]}}, hi_q};
  assign lo_x = {{2{lo_q[CW-1]}}, lo_q};

  for (genvar k = 0; k < NTHR; k++) begin : g_thr
    logic signed [CW-1:0] tv;
    assign tv         = thresh_i[k*CW +: CW];
    assign thr_hit[k] = (nxt == {{2{tv[CW-1]}}, tv});
  end

  always_comb begin
    step = '0;
    for (int i = 0; i < NCH; i++) begin
      if (up_i[i])        step = step + ONE;
      else if (down_i[i]) step = step - ONE;
    end
  end

  always_comb begin
    count_d = count_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    ev      = '0;
    run_d   = run_q;
    if (stop_i)       run_d = 1'b0;
    else if (start_i) run_d = 1'b1;
    if (clear_i) begin
      count_d = '0;
      if (lim_hi_i > ZERO && lim_hi_i <= LMAX) hi_d = lim_hi_i;
      if (lim_lo_i < ZERO && lim_lo_i >= LMIN) lo_d = lim_lo_i;
    end else if (run_q && step != '0) begin
      if (nxt >= hi_x) begin
        count_d     = '0;
        ev[EV_HIGH] = 1'b1;
      end else if (nxt <= lo_x) begin
        count_d    = '0;
        ev[EV_LOW] = 1'b1;
      end else begin
        count_d        = nxt[CW-1:0];
        ev[NTHR-1:0]   = thr_hit;
        ev[EV_ZERO]    = (nxt == '0);
      end
    end
    fire   = ev & evt_en_i;
    stat_d = (irq_clr_i ? '0 : stat_q) | fire;
    irq_d  = (irq_clr_i ? 1'b0 : irq_q) | (|fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      hi_q    <= LMAX;
      lo_q    <= LMIN;
      run_q   <= 1'b0;
      stat_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      run_q   <= run_d;
      stat_q  <= stat_d;
      irq_q   <= irq_d;
    end
  end

  assign count_o      = count_q;
  assign evt_status_o = stat_q;
  assign irq_o        = irq_q;
  assign act_hi_o     = hi_q;
  assign act_lo_o     = lo_q;
  assign run_o        = run_q;
endmodule

// File: rtl/pulse_counter_unit.sv
module pulse_counter_unit
  import pcnt_pkg::*;
#(
  parameter int CW      = 16,
  parameter int FW      = 10,
  parameter int LIM_MAX = 32767
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           edge_in_i,
  input  logic [1:0]           ctrl_in_i,
  input  logic [1:0]           edge_inv_i,
  input  logic [1:0]           ctrl_inv_i,
  input  logic [3:0]           pos_mode_i,
  input  logic [3:0]           neg_mode_i,
  input  logic [3:0]           hi_mode_i,
  input  logic [3:0]           lo_mode_i,
  input  logic                 glitch_en_i,
  input  logic [FW-1:0]        glitch_len_i,
  input  logic signed [CW-1:0] lim_hi_i,
  input  logic signed [CW-1:0] lim_lo_i,
  input  logic [2*CW-1:0]      thresh_i,
  input  logic [4:0]           evt_en_i,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic                 clear_i,
  input  logic                 irq_clr_i,
  output logic signed [CW-1:0] count_o,
  output logic [4:0]           evt_status_o,
  output logic                 irq_o
);
  localparam int NCH = 2;

  logic                 rst_s1_q, rst_int_n;
  logic [NCH-1:0]       ch_up, ch_down;
  logic signed [CW-1:0] act_hi, act_lo;
  logic                 running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_s1_q  <= 1'b1;
      rst_int_n <= rst_s1_q;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pcnt_chan #(.FW(FW)) chan_i (
      .clk(clk), .rst_n(rst_int_n),
      .edge_raw_i(edge_in_i[c]), .ctrl_raw_i(ctrl_in_i[c]),
      .edge_inv_i(edge_inv_i[c]), .ctrl_inv_i(ctrl_inv_i[c]),
      .filt_en_i(glitch_en_i), .filt_len_i(glitch_len_i),
      .pos_mode_i(pos_mode_i[2*c +: 2]), .neg_mode_i(neg_mode_i[2*c +: 2]),
      .hi_mode_i(hi_mode_i[2*c +: 2]), .lo_mode_i(lo_mode_i[2*c +: 2]),
      .up_o(ch_up[c]), .down_o(ch_down[c])
    );
  end

  pcnt_core #(.CW(CW), .LIM_MAX(LIM_MAX), .NCH(NCH)) core_i (
    .clk(clk), .rst_n(rst_int_n),
    .up_i(ch_up), .down_i(ch_down),
    .start_i(start_i), .stop_i(stop_i), .clear_i(clear_i), .irq_clr_i(irq_clr_i),
    .lim_hi_i(lim_hi_i), .lim_lo_i(lim_lo_i), .thresh_i(thresh_i),
    .evt_en_i(evt_en_i),
    .count_o(count_o), .evt_status_o(evt_status_o), .irq_o(irq_o),
    .act_hi_o(act_hi), .act_lo_o(act_lo), .run_o(running)
  );
endmodule

// File: rtl/pcnt_unit_checker.sv
module pcnt_unit_checker #(
  parameter int CW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clear_i,
  input logic signed [CW-1:0] count_o,
  input logic [4:0]           evt_status_o,
  input logic                 irq_o,
  input logic signed [CW-1:0] act_hi,
  input logic signed [CW-1:0] act_lo,
  input logic                 running
);
  // R8: count always strictly between the active limits
  assert_count_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o < act_hi) && (count_o > act_lo));

  // R9: active limits keep their signs
  assert_limits_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_hi > 0) && (act_lo < 0));

  // R7: clear yields zero count next cycle
  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (count_o == 0));

  // R6: stopped counter holds its value
  assert_stopped_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !clear_i) |=> $stable(count_o));

  // R12: interrupt flag never stands without a latched event
  assert_irq_has_status_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (evt_status_o != 5'd0));

  // R8: a new high-limit event coincides with a wrapped count
  assert_high_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_status_o[3]) |-> (count_o == 0));
endmodule

bind pulse_counter_unit pcnt_unit_checker #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .count_o(count_o),
  .evt_status_o(evt_status_o), .irq_o(irq_o), .act_hi(act_hi),
  .act_lo(act_lo), .running(running)
);

// File: tb/pulse_counter_unit_tb_top.sv
`timescale 1ns/1ps
module pulse_counter_unit_tb_top;
  localparam int CW = 16;
  localparam int FW = 10;
  localparam int LMAX = 32767;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] edge_in, ctrl_in, edge_inv, ctrl_inv;
  logic [3:0] pos_mode, neg_mode, hi_mode, lo_mode;
  logic glitch_en;
  logic [FW-1:0] glitch_len;
  logic signed [CW-1:0] lim_hi, lim_lo;
  logic [2*CW-1:0] thresh;
  logic [4:0] evt_en;
  logic start, stop, clear, irq_clr;
  logic signed [CW-1:0] count;
  logic [4:0] status;
  logic irq;

  int checks = 0, errors = 0;
  string phase = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  pulse_counter_unit #(.CW(CW), .FW(FW), .LIM_MAX(LMAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .edge_in_i(edge_in), .ctrl_in_i(ctrl_in),
    .edge_inv_i(edge_inv), .ctrl_inv_i(ctrl_inv), .pos_mode_i(pos_mode),
    .neg_mode_i(neg_mode), .hi_mode_i(hi_mode), .lo_mode_i(lo_mode),
    .glitch_en_i(glitch_en), .glitch_len_i(glitch_len), .lim_hi_i(lim_hi),
    .lim_lo_i(lim_lo), .thresh_i(thresh), .evt_en_i(evt_en), .start_i(start),
    .stop_i(stop), .clear_i(clear), .irq_clr_i(irq_clr), .count_o(count),
    .evt_status_o(status), .irq_o(irq)
  );

  // ---------------- behavioural reference model ----------------
  int rcnt;
  int s1[4], s2[4], fv[4], fc[4];   // index: 2*ch + (0 edge, 1 ctrl)
  int prev_e[2];
  int m_cnt, m_hi, m_lo, m_run, m_st, m_irq;

  function automatic int mode_at(logic [3:0] bus, int ch);
    return int'(bus[2*ch +: 2]);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin s1[i] = 0; s2[i] = 0; fv[i] = 0; fc[i] = 0; end
    for (int c = 0; c < 2; c++) prev_e[c] = 0;
    m_cnt = 0; m_hi = LMAX; m_lo = -LMAX; m_run = 0; m_st = 0; m_irq = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      rcnt = 0; model_reset();
    end else if (rcnt < 2) begin
      rcnt++; model_reset();
    end else begin
      int step, nxt, ev, fire, hv, lv, ta, tb;
      int e[2];
      step = 0;
      for (int c = 0; c < 2; c++) begin
        int l, em, lm, d;
        e[c] = fv[2*c] ^ int'(edge_inv[c]);
        l    = fv[2*c+1] ^ int'(ctrl_inv[c]);
        em = (e[c] == 1 && prev_e[c] == 0) ? mode_at(pos_mode, c) :
             (e[c] == 0 && prev_e[c] == 1) ? mode_at(neg_mode, c) : 0;
        d  = (em == 1) ? 1 : (em == 2) ? -1 : 0;
        lm = l ? mode_at(hi_mode, c) : mode_at(lo_mode, c);
        if (lm == 1) d = -d;
        else if (lm >= 2) d = 0;
        step += d;
      end
      nxt = m_cnt + step;
      ev = 0;
      hv = int'(lim_hi); lv = int'(lim_lo);
      ta = int'($signed(thresh[CW-1:0])); tb = int'($signed(thresh[2*CW-1:CW]));
      if (clear) begin
        m_cnt = 0;
        if (hv > 0 && hv <= LMAX) m_hi = hv;
        if (lv < 0 && lv >= -LMAX) m_lo = lv;
      end else if (m_run != 0 && step != 0) begin
        if (nxt >= m_hi) begin m_cnt = 0; ev = 8; end
        else if (nxt <= m_lo) begin m_cnt = 0; ev = 4; end
        else begin
          m_cnt = nxt;
          if (nxt == ta) ev |= 1;
          if (nxt == tb) ev |= 2;
          if (nxt == 0)  ev |= 16;
        end
      end
      if (stop) m_run = 0; else if (start) m_run = 1;
      fire  = ev & int'(evt_en);
      m_st  = (irq_clr ? 0 : m_st) | fire;
      m_irq = ((irq_clr ? 0 : m_irq) != 0 || fire != 0) ? 1 : 0;
      for (int c = 0; c < 2; c++) prev_e[c] = e[c];
      for (int i = 0; i < 4; i++) begin
        int raw;
        raw = (i % 2 == 0) ? int'(edge_in[i/2]) : int'(ctrl_in[i/2]);
        if (s2[i] != fv[i]) begin
          if (!glitch_en || fc[i] >= int'(glitch_len)) begin fv[i] = s2[i]; fc[i] = 0; end
          else fc[i]++;
        end else fc[i] = 0;
        s2[i] = s1[i];
        s1[i] = raw;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (int'(count) != m_cnt || int'(status) != m_st || int'(irq) != m_irq) begin
        errors++;
        $display("FAIL %s: count %0d status %b irq %0d, expected count %0d status %b irq %0d",
                 phase, count, status, irq, m_cnt, m_st[4:0], m_irq);
      end
    end
  end

  task automatic chk(int got, int exp, string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic [1:0] mask, int w);
    edge_in = edge_in | mask; tick(w);
    edge_in = edge_in & ~mask; tick(w);
  endtask

  task automatic pulses(logic [1:0] mask, int n);
    for (int i = 0; i < n; i++) pulse(mask, 3);
    tick(8);
  endtask

  task automatic strobe_clear();  clear = 1;   tick(1); clear = 0;   tick(1); endtask
  task automatic strobe_start();  start = 1;   tick(1); start = 0;   tick(1); endtask
  task automatic strobe_stop();   stop = 1;    tick(1); stop = 0;    tick(1); endtask
  task automatic strobe_irqclr(); irq_clr = 1; tick(1); irq_clr = 0; tick(1); endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    done = 1; errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int b;
    rst_n = 0; edge_in = 0; ctrl_in = 0; edge_inv = 0; ctrl_inv = 0;
    pos_mode = 0; neg_mode = 0; hi_mode = 0; lo_mode = 0;
    glitch_en = 0; glitch_len = 0; lim_hi = 100; lim_lo = -100;
    thresh = {16'sd50, -16'sd50}; evt_en = 5'h1f;
    start = 0; stop = 0; clear = 0; irq_clr = 0;
    tick(5); rst_n = 1; tick(5);

    phase = "R1";
    chk(int'(count), 0, "R1 count"); chk(int'(status), 0, "R1 status"); chk(int'(irq), 0, "R1 irq");

    pos_mode = 4'b0001; strobe_clear(); strobe_start();
    phase = "R2"; b = int'(count);
    pulses(2'b01, 3);  chk(int'(count), b + 3, "R2 up on rise");
    neg_mode = 4'b0010; pulses(2'b01, 1); chk(int'(count), b + 3, "R2 rise up fall down");
    neg_mode = 4'b0000;

    phase = "R3"; ctrl_in = 2'b01; hi_mode = 4'b0001; tick(6); b = int'(count);
    pulses(2'b01, 2); chk(int'(count), b - 2, "R3 reverse");
    hi_mode = 4'b0010; pulses(2'b01, 1); chk(int'(count), b - 2, "R3 hold");

    phase = "R4"; ctrl_inv = 2'b01; tick(6); b = int'(count);
    pulses(2'b01, 1); chk(int'(count), b + 1, "R4 inverted ctrl keeps");
    ctrl_inv = 2'b00; ctrl_in = 2'b00; hi_mode = 4'b0000; tick(6);

    phase = "R5"; pos_mode = 4'b0101; b = int'(count);
    pulses(2'b11, 2); chk(int'(count), b + 4, "R5 both channels");

    phase = "R6"; strobe_stop(); b = int'(count);
    pulses(2'b11, 2); chk(int'(count), b, "R6 stopped");
    start = 1; stop = 1; tick(1); start = 0; stop = 0; tick(1);
    pulses(2'b11, 1); chk(int'(count), b, "R6 stop wins");
    strobe_start(); pulses(2'b01, 1); chk(int'(count), b + 1, "R6 restart");

    phase = "R7"; strobe_clear(); chk(int'(count), 0, "R7 clear");
    pulses(2'b01, 1); chk(int'(count), 1, "R7 still running");

    phase = "R8"; lim_hi = 5; lim_lo = -5; pos_mode = 4'b0001; strobe_clear(); strobe_irqclr();
    pulses(2'b01, 4); chk(int'(count), 4, "R8 below high");
    pulses(2'b01, 1); chk(int'(count), 0, "R8 wrap high"); chk(int'(status), 5'b01000, "R8 high bit");
    strobe_irqclr(); pos_mode = 4'b0010;
    pulses(2'b01, 5); chk(int'(count), 0, "R8 wrap low"); chk(int'(status), 5'b00100, "R8 low bit");

    phase = "R9"; lim_hi = 0; lim_lo = -3; pos_mode = 4'b0001; strobe_clear(); strobe_irqclr();
    pulses(2'b01, 4); chk(int'(count), 4, "R9 old high kept");
    pulses(2'b01, 1); chk(int'(count), 0, "R9 wrap at kept high");
    pos_mode = 4'b0010; pulses(2'b01, 3); chk(int'(count), 0, "R9 new low used");

    phase = "R10"; thresh = {-16'sd2, 16'sd2}; pos_mode = 4'b0001; strobe_irqclr();
    pulses(2'b01, 2); chk(int'(status), 5'b00001, "R10 thr A");

    phase = "R11"; pos_mode = 4'b0010; strobe_irqclr();
    pulses(2'b01, 2); chk(int'(status), 5'b10000, "R11 zero");
    strobe_irqclr(); pulses(2'b01, 2); chk(int'(status), 5'b00010, "R10 thr B");

    phase = "R12"; evt_en = 5'b01111; pos_mode = 4'b0001; strobe_irqclr();
    pulses(2'b01, 2); chk(int'(status), 0, "R12 disabled zero"); chk(int'(irq), 0, "R12 no irq");
    evt_en = 5'h1f;

    phase = "R13"; lim_hi = 100; lim_lo = -100; strobe_clear();
    glitch_en = 1; glitch_len = 3; tick(4); b = int'(count);
    for (int i = 0; i < 3; i++) pulse(2'b01, 3);
    tick(12); chk(int'(count), b, "R13 short pulses dropped");
    pulse(2'b01, 6); tick(12); chk(int'(count), b + 1, "R13 long pulse kept");

    tick(4);
    done = 1;
    summary();
    $finish;
  end
endmodule